// File: doc/BRIEF.md
# Up/Down Presettable Decade Counter

One counter digit that steps up or down on each rising clock edge, under a direction input. Each digit holds a 4-bit value. A parameter sets the modulus to 10, giving BCD decade operation, or to 16, giving plain binary operation. Both settings present the same pins.

A parallel load takes an arbitrary value from the data bus. The load is sampled on the clock edge and overrides counting. Counting runs only while the active-low enable is low.

Two flags report the terminal state for the current direction:

- `max_min` is high when the digit sits at the top of its range while counting up, or at zero while counting down.
- `ripple_n` is an active-low pulse. It is low only during the low half of a clock period in which the digit is enabled and at its terminal state.

Digits are chained by feeding one digit's `ripple_n` to the clock input of the next, more significant digit. The pulse ends, and so gives a rising edge, on the same clock edge that wraps the lower digit. There is no streaming data path, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `updown_digit_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0.
- R2: `load_n` low at a rising clock edge copies `din` into `count`, whatever the values of `cnt_en_n` and `down`.
- R3: With `load_n` high and `cnt_en_n` high at an edge, `count` keeps its value.
- R4: With `down` = 0 (up), `load_n` high and `cnt_en_n` low, each edge adds one, and the last state (9 in decade mode, 15 in binary mode) is followed by 0.
- R5: With `down` = 1 (down), `load_n` high and `cnt_en_n` low, each edge subtracts one, and 0 is followed by the last state (9 or 15).
- R6: `max_min` is 1 exactly when `count` equals the last state with `down` = 0, or 0 with `down` = 1, independent of `cnt_en_n`.
- R7: `ripple_n` is 0 only while `clk` is low, `cnt_en_n` is low and `max_min` is 1; otherwise it is 1.
- R8: In decade mode, a loaded value from 10 to 15 goes to 0 on the next enabled edge when counting up, or to 9 when counting down. Every enabled count edge leaves `count` at 9 or below.
- R9: With the modulus parameter set to 16, values 10 to 15 are ordinary states, and R4 to R7 apply with 15 as the last state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Asynchronous reset to 0, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Parallel load, active low, sampled on the edge |
| din | input | 4 | Value to load |
| count | output | 4 | Current digit value |
| max_min | output | 1 | Terminal state for the current direction |
| ripple_n | output | 1 | Active-low terminal pulse gated by the low clock phase and the enable |

## Verification
The embedded properties check the following on every cycle:

- the load and hold behaviour;
- the legal range after any enabled step;
- the tie between `max_min`, `count` and `down`;
- that `ripple_n` is high during each high clock phase.

Only the scenarios in the bench can show the following:

- the full up and down sequences, including each wrap;
- recovery from illegal loaded values;
- loads issued in the middle of a count;
- the binary-mode states from 10 to 15.

In those scenarios a behavioural model runs alongside both a decade instance and a binary instance.

// File: rtl/updc_pkg.sv
package updc_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/updc_next.sv
module updc_next
  import updc_pkg::*;
#(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input  logic [W-1:0] cur,
  input  dir_e         dir,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic at_top_or_above;

  generate
    if (MOD < (1 << W)) begin : g_truncated
      // states above LAST exist and are treated as past the top
      assign at_top_or_above = (cur >= LAST);
    end else begin : g_full
      assign at_top_or_above = (cur == LAST);
    end
  endgenerate

  always_comb begin
    if (dir == DIR_UP) begin
      nxt = at_top_or_above ? '0 : cur + W'(1);
    end else begin
      nxt = (cur == '0 || cur > LAST) ? LAST : cur - W'(1);
    end
  end
endmodule

// File: rtl/updc_term.sv
module updc_term
  import updc_pkg::*;
#(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  dir_e         dir,
  input  logic         en_n,
  output logic         term,
  output logic         ripple_n
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  assign term     = (dir == DIR_UP) ? (cur == LAST) : (cur == '0);
  assign ripple_n = ~(~clk & ~en_n & term);

  // R7
  ripple_high_in_high_phase_chk: assert property (
    @(negedge clk) disable iff (!rst_n) ripple_n);
endmodule

// File: rtl/updown_digit_counter.sv
module updown_digit_counter
  import updc_pkg::*;
#(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en_n,
  input  logic         down,
  input  logic         load_n,
  input  logic [3:0]   din,
  output logic [3:0]   count,
  output logic         max_min,
  output logic         ripple_n
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  dir_e         dir;
  logic [W-1:0] state_q;
  logic [W-1:0] step_val;

  assign dir = dir_e'(down);

  updc_next #(.W(W), .MOD(MOD)) u_next (
    .cur (state_q),
    .dir (dir),
    .nxt (step_val)
  );

  updc_term #(.W(W), .MOD(MOD)) u_term (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (state_q),
    .dir      (dir),
    .en_n     (cnt_en_n),
    .term     (max_min),
    .ripple_n (ripple_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (!load_n) begin
      state_q <= din;
    end else if (!cnt_en_n) begin
      state_q <= step_val;
    end
  end

  assign count = state_q;

  // R1
  reset_zero_chk: assert property (
    @(posedge clk) !rst_n |-> count == '0);

  // R2
  load_takes_data_chk: assert property (
    @(posedge clk) disable iff (!rst_n) !load_n |=> count == $past(din));

  // R3
  hold_when_idle_chk: assert property (
    @(posedge clk) disable iff (!rst_n) (load_n && cnt_en_n) |=> $stable(count));

  // R8
  legal_after_step_chk: assert property (
    @(posedge clk) disable iff (!rst_n) (load_n && !cnt_en_n) |=> count <= LAST);

  // R6
  flag_matches_state_chk: assert property (
    @(posedge clk) disable iff (!rst_n)
      max_min == (down ? (count == '0) : (count == LAST)));
endmodule

// File: tb/updown_digit_counter_test.sv
module updown_digit_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en_n = 1'b1;
  logic       down = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt_d, cnt_b;
  logic       mm_d, mm_b, rn_d, rn_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updown_digit_counter #(.W(4), .MOD(10)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .down(down),
    .load_n(load_n), .din(din), .count(cnt_d), .max_min(mm_d), .ripple_n(rn_d));

  updown_digit_counter #(.W(4), .MOD(16)) uut_bin (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .down(down),
    .load_n(load_n), .din(din), .count(cnt_b), .max_min(mm_b), .ripple_n(rn_b));

  typedef struct {
    int    cd;
    int    cb;
    bit    md;
    bit    mb;
    string tag;
  } exp_t;

  exp_t sb[$];
  int model_d = 0;
  int model_b = 0;

  function automatic int nx(int c, bit ldn, bit enn, bit dn, int d, int m);
    if (!ldn) return d;
    if (enn) return c;
    if (!dn) return (c >= m - 1) ? 0 : c + 1;
    return (c == 0 || c > m - 1) ? m - 1 : c - 1;
  endfunction

  function automatic bit term(int c, bit dn, int m);
    return dn ? (c == 0) : (c == m - 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: checks ripple for the ongoing low phase, then applies one step
  task automatic step(bit ldn, bit enn, bit dn, int d, string tag);
    exp_t e;
    @(negedge clk);
    #1;
    chk(rn_d == !(!cnt_en_n && term(model_d, down, 10)), "R7 decade ripple", rn_d,
        !(!cnt_en_n && term(model_d, down, 10)));
    chk(rn_b == !(!cnt_en_n && term(model_b, down, 16)), "R7 binary ripple", rn_b,
        !(!cnt_en_n && term(model_b, down, 16)));
    load_n = ldn; cnt_en_n = enn; down = dn; din = 4'(d);
    model_d = nx(model_d, ldn, enn, dn, d, 10);
    model_b = nx(model_b, ldn, enn, dn, d, 16);
    e.cd = model_d; e.cb = model_b;
    e.md = term(model_d, dn, 10); e.mb = term(model_b, dn, 16);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares after each rising edge, during the high phase
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(cnt_d == 4'(e.cd), {e.tag, " decade count"}, cnt_d, e.cd);
        chk(cnt_b == 4'(e.cb), {e.tag, " binary count"}, cnt_b, e.cb);
        chk(mm_d == e.md, "R6 decade max_min", mm_d, e.md);
        chk(mm_b == e.mb, "R6 binary max_min", mm_b, e.mb);
        chk(rn_d && rn_b, "R7 ripple high in high phase", rn_d & rn_b, 1);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk(cnt_d == 4'd0, "R1 reset decade", cnt_d, 0);
    chk(cnt_b == 4'd0, "R1 reset binary", cnt_b, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R4 up through both wraps
    for (int i = 0; i < 18; i++) step(1, 0, 0, 0, "R4 up");
    // R3 hold
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R3 hold");
    // R5 down through wraps
    for (int i = 0; i < 20; i++) step(1, 0, 1, 0, "R5 down");
    // R2 load mid-count, enable low, then keep counting
    step(0, 0, 0, 7, "R2 load while enabled");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R4 up after load");
    step(0, 1, 1, 3, "R2 load while disabled");
    step(1, 0, 1, 0, "R5 down after load");
    // R8 illegal decade values, R9 binary high states
    step(0, 1, 0, 12, "R8 load 12");
    step(1, 0, 0, 0, "R8 up from 12");
    step(0, 0, 1, 14, "R8 load 14");
    step(1, 0, 1, 0, "R8 down from 14");
    step(0, 1, 0, 15, "R9 load 15");
    step(1, 1, 0, 0, "R3 hold at 15");
    step(1, 0, 0, 0, "R9 up wrap from 15");
    step(0, 0, 1, 0, "R2 load 0");
    step(1, 0, 1, 0, "R9 down wrap from 0");
    step(1, 1, 1, 0, "R6 flag with enable high");
    step(1, 1, 0, 0, "R6 direction flip");
    @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule